// File: doc/BRIEF.md
# Ethernet Receive Frame Checker

This block takes the byte-wide receive stream coming from the PHY side and turns it into a checked frame stream for a DMA engine. It looks for the preamble and the start-of-frame delimiter, then forwards every frame byte, the trailing FCS included, with a valid strobe and a last mark. While the bytes pass through, it keeps a running CRC-32 and a byte count. It also latches the destination address for a downstream address filter and the type/length field for its own length check.

When the stream ends (receive data-valid drops), the block issues a single-cycle status with a good/bad flag. In the same cycle it pulses one line per error class toward a statistics block. There are two ways a frame can go wrong early: the count passes the current maximum size, or the PHY flags a symbol error. Either one stops forwarding at once and raises an immediate bad strobe, so the DMA side can drop its buffer early. A jumbo enable widens the maximum size from 1518 to 10240 bytes.

Top module: `eth_rx_frame_check`

## Requirements
- R1: A frame starts only when rx_dv_i rises on 0x55, is followed by zero or more further 0x55 bytes and then 0xD5. Any other byte during that phase makes the block ignore the rest of the burst, with no data, no status and no statistics.
- R2: Frame bytes after 0xD5, FCS included, appear on dma_data_o in arrival order, one per dma_valid_o cycle, with a one-byte delay. dma_last_o marks the final byte in the same cycle as status_valid_o.
- R3: Frame bytes 0 to 5 are latched with byte 0 in dest_addr_o[7:0] and byte 5 in [47:40]. dest_valid_o pulses exactly once per frame, one cycle after byte 5 is sampled.
- R4: A frame is good only if its length is legal, no receive error was seen, there is no length mismatch, and the CRC-32 (reflected, polynomial 0x04C11DB7, initial all ones) over all bytes including the FCS gives residue 0xDEBB20E3. A legal-length frame with a bad CRC and no dribble pulses stat_fcs_o.
- R5: rx_dribble_i seen during a legal-length frame with a bad CRC pulses stat_align_o instead of stat_fcs_o. Dribble alone does not make a frame bad.
- R6: A frame under 64 bytes is bad and pulses only stat_short_o.
- R7: With jumbo off, 1518 bytes is legal. On the 1519th byte, dma_bad_o pulses in the following cycle and no further dma_valid_o occurs for that frame.
- R8: An oversize frame pulses stat_long_o when its length is at most the jabber limit (2048 bytes with jumbo off), and stat_jabber_o when it is longer.
- R9: With jumbo_en_i set, frames up to 10240 bytes are good. A longer frame is aborted as in R7 and pulses stat_jabber_o.
- R10: rx_er_i high on a frame byte pulses dma_bad_o in the next cycle and stops forwarding. At the end of the frame the status is bad and stat_symbol_o pulses.
- R11: When the field in bytes 12 (high) and 13 (low) is below 0x0600, a legal frame with a good CRC whose length minus 18 differs from max(field, 46) is bad and pulses stat_lenmis_o.
- R12: Exactly one status_valid_o pulse follows each accepted frame. The status flag and statistics pulses are zero in every other cycle, and all outputs are zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Receive clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| jumbo_en_i | input | 1 | Raise maximum frame size to 10240 bytes |
| rx_dv_i | input | 1 | PHY receive data valid |
| rx_er_i | input | 1 | PHY receive symbol error |
| rx_dribble_i | input | 1 | Non-integral octet seen by the PHY |
| rx_data_i | input | 8 | PHY receive byte |
| dma_data_o | output | 8 | Forwarded frame byte |
| dma_valid_o | output | 1 | Forwarded byte valid |
| dma_last_o | output | 1 | Final byte of a frame |
| dma_bad_o | output | 1 | Mid-frame abort strobe |
| status_valid_o | output | 1 | End-of-frame status strobe |
| status_good_o | output | 1 | Frame passed all checks |
| dest_addr_o | output | 48 | Latched destination address |
| dest_valid_o | output | 1 | Destination address complete |
| stat_align_o | output | 1 | Alignment error pulse |
| stat_fcs_o | output | 1 | FCS error pulse |
| stat_short_o | output | 1 | Short frame pulse |
| stat_long_o | output | 1 | Long frame pulse |
| stat_jabber_o | output | 1 | Jabber pulse |
| stat_symbol_o | output | 1 | Receive symbol error pulse |
| stat_lenmis_o | output | 1 | Length field mismatch pulse |

## Verification
Frames built in the bench carry a real FCS. They are sent with lengths that straddle each size limit (60, 64, 1518/1519, 2048/2049, 10240/10241) and with the jumbo enable both off and on, which separates long from jabber and legal from oversize. Type/length values below, at and above the 46-byte pad boundary, plus a plain EtherType, separate padded frames from real mismatches. A corrupted FCS with and without dribble separates alignment from FCS errors, and a dribble on a clean frame shows that dribble alone passes. Mid-frame receive errors, a stray first byte and a delimiter with no preamble exercise the abort and the preamble rejection.

// File: rtl/eth_rx_pkg.sv
package eth_rx_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_PRE, ST_DATA, ST_DROP} rx_state_e;

  localparam logic [7:0]  PRE_BYTE    = 8'h55;
  localparam logic [7:0]  SFD_BYTE    = 8'hD5;
  localparam logic [31:0] CRC_INIT    = 32'hFFFF_FFFF;
  localparam logic [31:0] CRC_POLY_R  = 32'hEDB8_8320;
  localparam logic [31:0] CRC_RESIDUE = 32'hDEBB_20E3;
  localparam int ADDR_BYTES  = 6;
  localparam int LT_HI_IDX   = 12;
  localparam int LT_LO_IDX   = 13;
  localparam int HDR_FCS_LEN = 18;
  localparam int MIN_PAYLOAD = 46;
  localparam logic [15:0] TYPE_FLOOR = 16'h0600;

  // stat vector bit order
  localparam int S_ALIGN = 6, S_FCS = 5, S_SHORT = 4, S_LONG = 3,
                 S_JAB = 2, S_SYM = 1, S_LENMIS = 0;

  function automatic logic [31:0] crc32_byte(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'h0, b};
    for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ CRC_POLY_R) : (r >> 1);
    return r;
  endfunction
endpackage

// File: rtl/rx_crc32.sv
module rx_crc32
  import eth_rx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       en_i,
  input  logic [7:0] data_i,
  output logic       ok_o
);
  logic [31:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    crc_q <= CRC_INIT;
    else if (clr_i) crc_q <= CRC_INIT;
    else if (en_i)  crc_q <= crc32_byte(crc_q, data_i);
  end

  // running value over data plus FCS lands on a fixed residue
  assign ok_o = (crc_q == CRC_RESIDUE);
endmodule

// File: rtl/rx_len_check.sv
module rx_len_check
  import eth_rx_pkg::*;
#(
  parameter int CNT_W     = 14,
  parameter int MIN_LEN   = 64,
  parameter int MAX_STD   = 1518,
  parameter int MAX_JUMBO = 10240,
  parameter int JAB_STD   = 2048
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             jumbo_i,
  input  logic [15:0]      lt_i,
  output logic             at_max_o,
  output logic             legal_o,
  output logic             short_o,
  output logic             long_o,
  output logic             jabber_o,
  output logic             lt_mismatch_o
);
  localparam logic [CNT_W-1:0] MIN_C   = CNT_W'(MIN_LEN);
  localparam logic [CNT_W-1:0] MAXS_C  = CNT_W'(MAX_STD);
  localparam logic [CNT_W-1:0] MAXJ_C  = CNT_W'(MAX_JUMBO);
  localparam logic [CNT_W-1:0] JABS_C  = CNT_W'(JAB_STD);
  localparam logic [15:0]      HDR_C   = 16'(HDR_FCS_LEN);
  localparam logic [15:0]      MINPL_C = 16'(MIN_PAYLOAD);

  logic [CNT_W-1:0] max_len, jab_len;
  logic [15:0]      payload, expect_pl;

  assign max_len  = jumbo_i ? MAXJ_C : MAXS_C;
  assign jab_len  = jumbo_i ? MAXJ_C : JABS_C;
  assign at_max_o = (cnt_i == max_len);
  assign short_o  = (cnt_i < MIN_C);
  assign legal_o  = !short_o && (cnt_i <= max_len);
  assign long_o   = (cnt_i > max_len) && (cnt_i <= jab_len);
  assign jabber_o = (cnt_i > jab_len);

  assign payload   = 16'(cnt_i) - HDR_C;
  assign expect_pl = (lt_i < MINPL_C) ? MINPL_C : lt_i;
  assign lt_mismatch_o = (lt_i < TYPE_FLOOR) && (payload != expect_pl);
endmodule

// File: rtl/eth_rx_frame_check.sv
module eth_rx_frame_check
  import eth_rx_pkg::*;
#(
  parameter int MIN_LEN   = 64,
  parameter int MAX_STD   = 1518,
  parameter int MAX_JUMBO = 10240,
  parameter int JAB_STD   = 2048,
  localparam int CNT_W    = $clog2(MAX_JUMBO + 2) + 1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        jumbo_en_i,
  input  logic        rx_dv_i,
  input  logic        rx_er_i,
  input  logic        rx_dribble_i,
  input  logic [7:0]  rx_data_i,
  output logic [7:0]  dma_data_o,
  output logic        dma_valid_o,
  output logic        dma_last_o,
  output logic        dma_bad_o,
  output logic        status_valid_o,
  output logic        status_good_o,
  output logic [47:0] dest_addr_o,
  output logic        dest_valid_o,
  output logic        stat_align_o,
  output logic        stat_fcs_o,
  output logic        stat_short_o,
  output logic        stat_long_o,
  output logic        stat_jabber_o,
  output logic        stat_symbol_o,
  output logic        stat_lenmis_o
);
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_BYTES - 1);
  localparam logic [CNT_W-1:0] LT_HI     = CNT_W'(LT_HI_IDX);
  localparam logic [CNT_W-1:0] LT_LO     = CNT_W'(LT_LO_IDX);

  rx_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [7:0]       hold_q;
  logic             hold_v_q, abort_q, er_q, drib_q;
  logic [15:0]      lt_q;
  logic [47:0]      addr_q;
  logic [6:0]       stat_q, stat_c;
  logic             good_c, crc_ok, crc_clr, crc_en;
  logic             at_max, legal, is_short, is_long, is_jab, lt_mis;
  logic             in_byte;

  assign in_byte = (state_q == ST_DATA) && rx_dv_i;
  assign crc_clr = (state_q == ST_PRE) && rx_dv_i && (rx_data_i == SFD_BYTE);
  assign crc_en  = in_byte;

  rx_crc32 u_crc (
    .clk_i, .rst_ni, .clr_i(crc_clr), .en_i(crc_en), .data_i(rx_data_i), .ok_o(crc_ok)
  );

  rx_len_check #(
    .CNT_W(CNT_W), .MIN_LEN(MIN_LEN), .MAX_STD(MAX_STD),
    .MAX_JUMBO(MAX_JUMBO), .JAB_STD(JAB_STD)
  ) u_len (
    .cnt_i(cnt_q), .jumbo_i(jumbo_en_i), .lt_i(lt_q), .at_max_o(at_max),
    .legal_o(legal), .short_o(is_short), .long_o(is_long), .jabber_o(is_jab),
    .lt_mismatch_o(lt_mis)
  );

  // end-of-frame classification; CRC classes only for legal, error-free lengths
  always_comb begin
    stat_c           = '0;
    stat_c[S_ALIGN]  = legal && !er_q && !crc_ok && drib_q;
    stat_c[S_FCS]    = legal && !er_q && !crc_ok && !drib_q;
    stat_c[S_SHORT]  = is_short;
    stat_c[S_LONG]   = is_long;
    stat_c[S_JAB]    = is_jab;
    stat_c[S_SYM]    = er_q;
    stat_c[S_LENMIS] = legal && !er_q && crc_ok && lt_mis;
    good_c           = legal && !er_q && crc_ok && !lt_mis;
  end

  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_addr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) addr_q[g*8 +: 8] <= '0;
      else if (in_byte && cnt_q == CNT_W'(g)) addr_q[g*8 +: 8] <= rx_data_i;
    end
  end
  assign dest_addr_o = addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q        <= ST_IDLE;
      cnt_q          <= '0;
      hold_q         <= '0;
      hold_v_q       <= 1'b0;
      abort_q        <= 1'b0;
      er_q           <= 1'b0;
      drib_q         <= 1'b0;
      lt_q           <= '0;
      dma_data_o     <= '0;
      dma_valid_o    <= 1'b0;
      dma_last_o     <= 1'b0;
      dma_bad_o      <= 1'b0;
      status_valid_o <= 1'b0;
      status_good_o  <= 1'b0;
      dest_valid_o   <= 1'b0;
      stat_q         <= '0;
    end else begin
      dma_valid_o    <= 1'b0;
      dma_last_o     <= 1'b0;
      dma_bad_o      <= 1'b0;
      status_valid_o <= 1'b0;
      status_good_o  <= 1'b0;
      dest_valid_o   <= 1'b0;
      stat_q         <= '0;
      unique case (state_q)
        ST_IDLE: if (rx_dv_i) state_q <= (rx_data_i == PRE_BYTE) ? ST_PRE : ST_DROP;
        ST_PRE: begin
          if (!rx_dv_i) state_q <= ST_IDLE;
          else if (rx_data_i == SFD_BYTE) begin
            state_q  <= ST_DATA;
            cnt_q    <= '0;
            hold_v_q <= 1'b0;
            abort_q  <= 1'b0;
            er_q     <= 1'b0;
            drib_q   <= 1'b0;
            lt_q     <= '0;
          end else if (rx_data_i != PRE_BYTE) state_q <= ST_DROP;
        end
        ST_DATA: begin
          if (rx_dv_i) begin
            if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
            if (rx_er_i) er_q <= 1'b1;
            if (rx_dribble_i) drib_q <= 1'b1;
            if (cnt_q == ADDR_LAST) dest_valid_o <= 1'b1;
            if (cnt_q == LT_HI) lt_q[15:8] <= rx_data_i;
            if (cnt_q == LT_LO) lt_q[7:0]  <= rx_data_i;
            if (!abort_q) begin
              if (rx_er_i || at_max) begin
                abort_q   <= 1'b1;
                dma_bad_o <= 1'b1;
                hold_v_q  <= 1'b0;
              end else begin
                dma_valid_o <= hold_v_q;
                dma_data_o  <= hold_q;
                hold_q      <= rx_data_i;
                hold_v_q    <= 1'b1;
              end
            end
          end else begin
            state_q        <= ST_IDLE;
            dma_valid_o    <= hold_v_q && !abort_q;
            dma_last_o     <= hold_v_q && !abort_q;
            dma_data_o     <= hold_q;
            hold_v_q       <= 1'b0;
            status_valid_o <= 1'b1;
            status_good_o  <= good_c;
            stat_q         <= stat_c;
          end
        end
        ST_DROP: if (!rx_dv_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign stat_align_o  = stat_q[S_ALIGN];
  assign stat_fcs_o    = stat_q[S_FCS];
  assign stat_short_o  = stat_q[S_SHORT];
  assign stat_long_o   = stat_q[S_LONG];
  assign stat_jabber_o = stat_q[S_JAB];
  assign stat_symbol_o = stat_q[S_SYM];
  assign stat_lenmis_o = stat_q[S_LENMIS];

  p_bad_stops_fwd_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_bad_o |=> !dma_valid_o);
  p_bad_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_bad_o |=> !dma_bad_o);
  p_last_with_status_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_last_o |-> status_valid_o);
  p_stats_only_at_status_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_valid_o |-> (stat_q == '0 && !status_good_o));
  p_size_class_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({stat_short_o, stat_long_o, stat_jabber_o}));
  p_good_clean_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_good_o |-> (stat_q == '0));
  p_dest_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dest_valid_o |=> !dest_valid_o);
endmodule

// File: tb/eth_rx_frame_check_bench.sv
`timescale 1ns/1ps
module eth_rx_frame_check_bench;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic jumbo_en_i = 1'b0, rx_dv_i = 1'b0, rx_er_i = 1'b0, rx_dribble_i = 1'b0;
  logic [7:0] rx_data_i = '0;
  logic [7:0] dma_data_o;
  logic dma_valid_o, dma_last_o, dma_bad_o, status_valid_o, status_good_o, dest_valid_o;
  logic [47:0] dest_addr_o;
  logic stat_align_o, stat_fcs_o, stat_short_o, stat_long_o, stat_jabber_o, stat_symbol_o, stat_lenmis_o;

  always #2 clk_i = ~clk_i;

  eth_rx_frame_check u_eth_rx_frame_check (.*);

  localparam logic [47:0] EXP_DA = 48'h504F3E2D1C03;
  localparam logic [15:0] NO_ER  = 16'hFFFF;

  typedef struct packed {
    logic [15:0] len; logic jumbo; logic bad_fcs; logic drib;
    logic [15:0] er_at; logic [15:0] lt; logic good; logic [6:0] stats; logic [3:0] req;
  } vec_t;

  // stats: {align,fcs,short,long,jabber,symbol,lenmis}
  localparam int NV = 18;
  localparam vec_t VECS [0:NV-1] = '{
    '{16'd64,    1'b0, 1'b0, 1'b0, NO_ER,  16'h0800, 1'b1, 7'b0000000, 4'd4},
    '{16'd100,   1'b0, 1'b0, 1'b0, NO_ER,  16'h0800, 1'b1, 7'b0000000, 4'd4},
    '{16'd64,    1'b0, 1'b0, 1'b0, NO_ER,  16'd46,   1'b1, 7'b0000000, 4'd11},
    '{16'd64,    1'b0, 1'b0, 1'b0, NO_ER,  16'd16,   1'b1, 7'b0000000, 4'd11},
    '{16'd70,    1'b0, 1'b0, 1'b0, NO_ER,  16'd32,   1'b0, 7'b0000001, 4'd11},
    '{16'd1500,  1'b0, 1'b0, 1'b0, NO_ER,  16'd1482, 1'b1, 7'b0000000, 4'd11},
    '{16'd64,    1'b0, 1'b1, 1'b0, NO_ER,  16'h0800, 1'b0, 7'b0100000, 4'd4},
    '{16'd64,    1'b0, 1'b1, 1'b1, NO_ER,  16'h0800, 1'b0, 7'b1000000, 4'd5},
    '{16'd64,    1'b0, 1'b0, 1'b1, NO_ER,  16'h0800, 1'b1, 7'b0000000, 4'd5},
    '{16'd60,    1'b0, 1'b0, 1'b0, NO_ER,  16'h0800, 1'b0, 7'b0010000, 4'd6},
    '{16'd1518,  1'b0, 1'b0, 1'b0, NO_ER,  16'h0800, 1'b1, 7'b0000000, 4'd7},
    '{16'd1519,  1'b0, 1'b0, 1'b0, NO_ER,  16'h0800, 1'b0, 7'b0001000, 4'd7},
    '{16'd2048,  1'b0, 1'b0, 1'b0, NO_ER,  16'h0800, 1'b0, 7'b0001000, 4'd8},
    '{16'd2049,  1'b0, 1'b0, 1'b0, NO_ER,  16'h0800, 1'b0, 7'b0000100, 4'd8},
    '{16'd1519,  1'b1, 1'b0, 1'b0, NO_ER,  16'h0800, 1'b1, 7'b0000000, 4'd9},
    '{16'd10240, 1'b1, 1'b0, 1'b0, NO_ER,  16'h0800, 1'b1, 7'b0000000, 4'd9},
    '{16'd10241, 1'b1, 1'b0, 1'b0, NO_ER,  16'h0800, 1'b0, 7'b0000100, 4'd9},
    '{16'd100,   1'b0, 1'b0, 1'b0, 16'd30, 16'h0800, 1'b0, 7'b0000010, 4'd10}
  };

  int tests = 0, fails = 0;
  int cur_len = 0;
  logic [15:0] cur_lt = '0;
  logic [31:0] cur_fcs = '0;

  // monitor totals (written only by the monitor)
  int m_valid = 0, m_last = 0, m_bad = 0, m_stat = 0, m_destv = 0, m_derr = 0, m_idx = 0;
  int m_sc [7] = '{default: 0};
  logic m_good = 1'b0;

  function automatic string rq(input logic [3:0] c);
    case (c)
      4'd1: return "R1";   4'd2: return "R2";   4'd3: return "R3";
      4'd4: return "R4";   4'd5: return "R5";   4'd6: return "R6";
      4'd7: return "R7";   4'd8: return "R8";   4'd9: return "R9";
      4'd10: return "R10"; 4'd11: return "R11"; default: return "R12";
    endcase
  endfunction

  function automatic logic [7:0] byte_at(input int i, input logic [15:0] lt);
    logic [47:0] da;
    da = EXP_DA;
    if (i < 6) return da[i*8 +: 8];
    if (i < 12) return 8'hA0 + 8'(i);
    if (i == 12) return lt[15:8];
    if (i == 13) return lt[7:0];
    return 8'(i * 13 + 5);
  endfunction

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'h0, b};
    for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  function automatic logic [7:0] exp_byte(input int i);
    if (i < cur_len - 4) return byte_at(i, cur_lt);
    return cur_fcs[(i - (cur_len - 4))*8 +: 8];
  endfunction

  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (dma_valid_o) begin
        if (dma_data_o !== exp_byte(m_idx)) m_derr <= m_derr + 1;
        m_idx <= m_idx + 1;
        m_valid <= m_valid + 1;
      end
      if (dma_last_o) m_last <= m_last + 1;
      if (dma_bad_o) m_bad <= m_bad + 1;
      if (dest_valid_o) m_destv <= m_destv + 1;
      if (status_valid_o) begin
        m_stat <= m_stat + 1;
        m_good <= status_good_o;
        m_idx <= 0;
      end
      if (stat_align_o)  m_sc[6] <= m_sc[6] + 1;
      if (stat_fcs_o)    m_sc[5] <= m_sc[5] + 1;
      if (stat_short_o)  m_sc[4] <= m_sc[4] + 1;
      if (stat_long_o)   m_sc[3] <= m_sc[3] + 1;
      if (stat_jabber_o) m_sc[2] <= m_sc[2] + 1;
      if (stat_symbol_o) m_sc[1] <= m_sc[1] + 1;
      if (stat_lenmis_o) m_sc[0] <= m_sc[0] + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send_frame(input int len, input logic [15:0] lt, input bit bad_fcs,
                            input bit drib, input int er_at, input int npre, input logic [7:0] lead,
                            input bit use_lead);
    logic [31:0] c;
    cur_len = len;
    cur_lt  = lt;
    c = 32'hFFFFFFFF;
    for (int i = 0; i < len - 4; i++) c = crc_step(c, byte_at(i, lt));
    cur_fcs = ~c ^ (bad_fcs ? 32'h1 : 32'h0);
    if (use_lead) begin
      @(negedge clk_i); rx_dv_i = 1'b1; rx_data_i = lead;
    end
    for (int i = 0; i < npre; i++) begin
      @(negedge clk_i); rx_dv_i = 1'b1; rx_data_i = 8'h55;
    end
    @(negedge clk_i); rx_dv_i = 1'b1; rx_data_i = 8'hD5;
    for (int i = 0; i < len; i++) begin
      @(negedge clk_i);
      rx_data_i    = exp_byte(i);
      rx_er_i      = (i == er_at);
      rx_dribble_i = drib && (i == len - 1);
    end
    @(negedge clk_i);
    rx_dv_i = 1'b0; rx_er_i = 1'b0; rx_dribble_i = 1'b0; rx_data_i = '0;
    repeat (4) @(negedge clk_i);
  endtask

  initial begin
    #800000;
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // reset state
    chk(dma_valid_o == 0 && status_valid_o == 0 && dma_bad_o == 0, "R12", "reset outputs",
        {dma_valid_o, status_valid_o, dma_bad_o}, 0);
    chk(dest_addr_o == 48'h0, "R12", "reset dest", dest_addr_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    for (int v = 0; v < NV; v++) begin
      int s_valid, s_last, s_bad, s_stat, s_destv, s_derr, mx, efwd;
      int s_sc [7];
      bit abort;
      logic [6:0] got;
      int npulse;
      vec_t t;
      t = VECS[v];
      s_valid = m_valid; s_last = m_last; s_bad = m_bad; s_stat = m_stat;
      s_destv = m_destv; s_derr = m_derr;
      for (int k = 0; k < 7; k++) s_sc[k] = m_sc[k];
      jumbo_en_i = t.jumbo;
      send_frame(int'(t.len), t.lt, t.bad_fcs, t.drib, (t.er_at == NO_ER) ? -1 : int'(t.er_at),
                 7, 8'h00, 1'b0);
      mx = t.jumbo ? 10240 : 1518;
      abort = (t.er_at != NO_ER) || (int'(t.len) > mx);
      efwd = (t.er_at != NO_ER) ? int'(t.er_at) - 1 : (abort ? mx - 1 : int'(t.len));
      got = '0; npulse = 0;
      for (int k = 0; k < 7; k++) begin
        got[k] = (m_sc[k] != s_sc[k]);
        npulse += m_sc[k] - s_sc[k];
      end
      chk(m_stat - s_stat == 1, "R12", "status pulses", m_stat - s_stat, 1);
      chk(m_good == t.good, rq(t.req), "good flag", m_good, t.good);
      chk(got == t.stats && npulse == $countones(t.stats), rq(t.req), "stat pulses", got, t.stats);
      chk(m_bad - s_bad == (abort ? 1 : 0), abort ? rq(t.req) : "R2", "bad strobe", m_bad - s_bad, abort);
      chk(m_valid - s_valid == efwd, "R2", "bytes forwarded", m_valid - s_valid, efwd);
      chk(m_last - s_last == (abort ? 0 : 1), "R2", "last marks", m_last - s_last, !abort);
      chk(m_derr == s_derr, "R2", "byte order", m_derr - s_derr, 0);
      chk(dest_addr_o == EXP_DA && m_destv - s_destv == 1, "R3", "dest addr", dest_addr_o, EXP_DA);
    end
    jumbo_en_i = 1'b0;

    // R1: stray first byte drops whole burst
    begin
      int s_valid, s_stat;
      s_valid = m_valid; s_stat = m_stat;
      send_frame(80, 16'h0800, 1'b0, 1'b0, -1, 7, 8'h12, 1'b1);
      chk(m_stat == s_stat && m_valid == s_valid, "R1", "stray lead ignored", m_stat - s_stat, 0);
      // R1: delimiter with no preamble
      send_frame(80, 16'h0800, 1'b0, 1'b0, -1, 0, 8'h00, 1'b0);
      chk(m_stat == s_stat && m_valid == s_valid, "R1", "bare SFD ignored", m_valid - s_valid, 0);
      // R1: single preamble byte is enough
      send_frame(64, 16'h0800, 1'b0, 1'b0, -1, 1, 8'h00, 1'b0);
      chk(m_stat - s_stat == 1 && m_good == 1'b1, "R1", "short preamble accepted", m_good, 1);
    end

    // R12: reset mid-frame clears outputs, next frame is clean
    begin
      int s_stat;
      @(negedge clk_i); rx_dv_i = 1'b1; rx_data_i = 8'h55;
      @(negedge clk_i); rx_data_i = 8'hD5;
      repeat (10) begin @(negedge clk_i); rx_data_i = 8'h3C; end
      rst_ni = 1'b0; rx_dv_i = 1'b0;
      @(negedge clk_i);
      chk(dma_valid_o == 0 && status_valid_o == 0 && dest_addr_o == 0, "R12", "mid reset",
          dest_addr_o, 0);
      rst_ni = 1'b1;
      repeat (2) @(negedge clk_i);
      s_stat = m_stat;
      send_frame(64, 16'h0800, 1'b0, 1'b0, -1, 7, 8'h00, 1'b0);
      chk(m_stat - s_stat == 1 && m_good == 1'b1, "R12", "frame after reset", m_good, 1);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule